// File: doc/BRIEF.md
# Pipeline Idle Activity Tracker

This block tells a pipelined core when it can stop clocking. It keeps a short history register, one bit per cycle, that is as long as the longest latency between any two pipeline stages. Any stage that writes an inter-stage buffer raises a strobe, and that strobe marks the newest history slot. The history shifts by one slot every cycle, in step with the inter-stage buffers, so a marked slot stands for data that is still in flight. The block also keeps one active flag for each pipeline stage.

A single saturating counter holds the number of marked history slots plus the number of active stages. The counter is updated incrementally. It rises when a fresh slot is marked or a stage turns on. It falls when a marked slot leaves the oldest position or a stage turns off. All of these effects for one cycle are folded into a single net update. The core may idle while the counter is zero.

Software-free override: the count can be loaded with any value. Loading a large value keeps the core awake. A consistency flag reports any cycle in which the counter does not equal the true occupancy. The flag is held off once a load has occurred since reset.

Top module: `idle_track`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every history slot, every stage flag and the count. After reset `busy` is 0. The history stays empty after release, so `occMismatch` remains 0.
- R2: When one or more bits of `actStrobe` are high in a cycle, slot 0 of the history is marked, and the count rises by exactly 1 at the next edge, no matter how many strobe bits are set.
- R3: A slot marked at edge k is counted for HIST_LEN edges. The count drops by 1 at edge k+HIST_LEN, when that slot leaves the oldest position.
- R4: A high bit i of `stageSetReq` (with bit i of `stageClrReq` low) turns on the flag of stage i and raises the count by 1. A high bit i of `stageClrReq` (with the set bit low) turns the flag off and lowers the count by 1.
- R5: A set request for a stage that is already on has no effect. A clear request for a stage that is already off has no effect. Set and clear raised together for the same stage leave that stage unchanged.
- R6: In one cycle, the slot leaving the history, a new mark and every stage change are combined into a single net change of the count.
- R7: `busy` is 1 exactly when the count is nonzero.
- R8: When `loadEn` is high, the count takes `loadVal` at the next edge, ignoring that cycle's other count changes. History and stage flags keep updating as usual in that cycle.
- R9: The count saturates at 2^CNT_W-1 and at 0 instead of wrapping, where CNT_W = clog2(HIST_LEN+NUM_STAGES+1).
- R10: `occMismatch` is 1 in any cycle where the count differs from the number of marked slots plus the number of active stages. It is held at 0 once a load has taken place since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| actStrobe | input | NUM_WRITERS | One bit per buffer writer; any high bit marks the newest slot |
| stageSetReq | input | NUM_STAGES | Per-stage request to become active |
| stageClrReq | input | NUM_STAGES | Per-stage request to become inactive |
| loadEn | input | 1 | Load the count with loadVal |
| loadVal | input | CNT_W | Value to load |
| actCount | output | CNT_W | Current occupancy count |
| busy | output | 1 | Count is nonzero; core must stay clocked |
| occMismatch | output | 1 | Count disagrees with true occupancy (no load since reset) |

## Verification
The increment and decrement properties assume that the inputs are free of X once reset has been released. They also assume that a slot's ageing-out is not masked by a load in the same cycle. For this reason the single-step count properties are qualified on no load and on the count being away from its limits. The consistency property relies on the count staying exact before any load. This holds because the true occupancy never exceeds HIST_LEN+NUM_STAGES, which the counter width always covers. The directed stimulus drives every input at the falling edge and keeps set and clear requests well defined. Saturation is only pushed at by loading values at the limits, which is the only way the count can leave the exact range.

// File: rtl/idle_track_pkg.sv
package idle_track_pkg;
  // Per-cycle strobes from the control half to the counter datapath.
  typedef struct packed {
    logic markNew;  // newest slot gets marked this cycle
    logic ageOut;   // a marked slot leaves the oldest position
    logic loadHit;  // count override this cycle
  } trkStrobe_t;
endpackage

// File: rtl/idle_track_ctrl.sv
module idle_track_ctrl
  import idle_track_pkg::*;
#(
  parameter int HIST_LEN    = 4,
  parameter int NUM_STAGES  = 4,
  parameter int NUM_WRITERS = 3,
  parameter int CNT_W       = 4,
  parameter int UPD_W       = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_WRITERS-1:0] actStrobe,
  input  logic [NUM_STAGES-1:0]  stageSetReq,
  input  logic [NUM_STAGES-1:0]  stageClrReq,
  input  logic                  loadEn,
  output trkStrobe_t            strobes,
  output logic [UPD_W-1:0]      stageUp,
  output logic [UPD_W-1:0]      stageDown,
  output logic [CNT_W-1:0]      occupancy
);
  logic [HIST_LEN-1:0]   hist;
  logic [HIST_LEN-1:0]   histNext;
  logic [NUM_STAGES-1:0] stageFlag;
  logic [NUM_STAGES-1:0] turnOn;
  logic [NUM_STAGES-1:0] turnOff;
  logic                  anyWrite;

  assign anyWrite = |actStrobe;

  generate
    if (HIST_LEN == 1) begin : g_single
      assign histNext = anyWrite;
    end else begin : g_shift
      assign histNext = {hist[HIST_LEN-2:0], anyWrite};
    end
  endgenerate

  // Only real transitions count; redundant or conflicting requests drop out.
  assign turnOn  = stageSetReq & ~stageClrReq & ~stageFlag;
  assign turnOff = stageClrReq & ~stageSetReq &  stageFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      stageFlag <= '0;
    end else begin
      hist      <= histNext;
      stageFlag <= (stageFlag | turnOn) & ~turnOff;
    end
  end

  always_comb begin
    stageUp   = '0;
    stageDown = '0;
    occupancy = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      stageUp   = stageUp   + UPD_W'(turnOn[i]);
      stageDown = stageDown + UPD_W'(turnOff[i]);
      occupancy = occupancy + CNT_W'(stageFlag[i]);
    end
    for (int j = 0; j < HIST_LEN; j++) begin
      occupancy = occupancy + CNT_W'(hist[j]);
    end
  end

  assign strobes.markNew = anyWrite;
  assign strobes.ageOut  = hist[HIST_LEN-1];
  assign strobes.loadHit = loadEn;

  // R1: reset empties history and flags
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (hist == '0) && (stageFlag == '0));

  // R2: a strobe lands in slot 0
  a_r2_mark_slot0: assert property (@(posedge clk) disable iff (rst)
    (|actStrobe) |=> hist[0]);

  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage_chk
      // R4: set request turns the stage on, clear turns it off
      a_r4_stage_on: assert property (@(posedge clk) disable iff (rst)
        (stageSetReq[s] && !stageClrReq[s]) |=> stageFlag[s]);
      a_r4_stage_off: assert property (@(posedge clk) disable iff (rst)
        (stageClrReq[s] && !stageSetReq[s]) |=> !stageFlag[s]);
      // R5: conflicting requests leave the stage alone
      a_r5_conflict_hold: assert property (@(posedge clk) disable iff (rst)
        (stageClrReq[s] && stageSetReq[s]) |=> $stable(stageFlag[s]));
    end
  endgenerate
endmodule

// File: rtl/idle_track_dp.sv
module idle_track_dp
  import idle_track_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int UPD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  trkStrobe_t       strobes,
  input  logic [UPD_W-1:0] stageUp,
  input  logic [UPD_W-1:0] stageDown,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             overridden
);
  localparam int SUM_W = ((CNT_W > UPD_W) ? CNT_W : UPD_W) + 2;
  localparam logic [CNT_W-1:0] MAXCNT = '1;

  logic [SUM_W-1:0] upSum;
  logic [SUM_W-1:0] downSum;
  logic [SUM_W-1:0] diff;
  logic [CNT_W-1:0] netNext;

  // One-step net update with clamping at both ends.
  always_comb begin
    upSum   = SUM_W'(count) + SUM_W'(strobes.markNew) + SUM_W'(stageUp);
    downSum = SUM_W'(strobes.ageOut) + SUM_W'(stageDown);
    diff    = upSum - downSum;
    if (downSum > upSum)
      netNext = '0;
    else if (diff > SUM_W'(MAXCNT))
      netNext = MAXCNT;
    else
      netNext = CNT_W'(diff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      overridden <= 1'b0;
    end else if (strobes.loadHit) begin
      count      <= loadVal;
      overridden <= 1'b1;
    end else begin
      count      <= netNext;
    end
  end

  // R8: load wins over every other change
  a_r8_load_value: assert property (@(posedge clk) disable iff (rst)
    strobes.loadHit |=> count == $past(loadVal));

  // R2: a lone new mark raises the count by one
  a_r2_single_inc: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadHit && strobes.markNew && !strobes.ageOut &&
     stageUp == stageDown && count != MAXCNT)
    |=> count == $past(count) + CNT_W'(1));

  // R3: a lone aged-out slot lowers the count by one
  a_r3_single_dec: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadHit && !strobes.markNew && strobes.ageOut &&
     stageUp == stageDown && count != '0)
    |=> count == $past(count) - CNT_W'(1));

  // R9: no wrap at the top
  a_r9_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadHit && count == MAXCNT && !strobes.ageOut && stageDown == '0)
    |=> count == MAXCNT);

  // R9: no wrap at the bottom
  a_r9_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadHit && count == '0 && !strobes.markNew && stageUp == '0)
    |=> count == '0);
endmodule

// File: rtl/idle_track.sv
module idle_track
  import idle_track_pkg::*;
#(
  parameter int HIST_LEN    = 4,
  parameter int NUM_STAGES  = 4,
  parameter int NUM_WRITERS = 3,
  localparam int CNT_W      = $clog2(HIST_LEN + NUM_STAGES + 1),
  localparam int UPD_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_WRITERS-1:0] actStrobe,
  input  logic [NUM_STAGES-1:0]  stageSetReq,
  input  logic [NUM_STAGES-1:0]  stageClrReq,
  input  logic                   loadEn,
  input  logic [CNT_W-1:0]       loadVal,
  output logic [CNT_W-1:0]       actCount,
  output logic                   busy,
  output logic                   occMismatch
);
  trkStrobe_t       strobes;
  logic [UPD_W-1:0] stageUp;
  logic [UPD_W-1:0] stageDown;
  logic [CNT_W-1:0] occupancy;
  logic             overridden;

  idle_track_ctrl #(
    .HIST_LEN(HIST_LEN), .NUM_STAGES(NUM_STAGES), .NUM_WRITERS(NUM_WRITERS),
    .CNT_W(CNT_W), .UPD_W(UPD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .actStrobe(actStrobe),
    .stageSetReq(stageSetReq), .stageClrReq(stageClrReq), .loadEn(loadEn),
    .strobes(strobes), .stageUp(stageUp), .stageDown(stageDown),
    .occupancy(occupancy)
  );

  idle_track_dp #(.CNT_W(CNT_W), .UPD_W(UPD_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .stageUp(stageUp),
    .stageDown(stageDown), .loadVal(loadVal), .count(actCount),
    .overridden(overridden)
  );

  assign busy        = (actCount != '0);
  assign occMismatch = !overridden && (actCount != occupancy);

  // R10: without a load, the incremental count tracks true occupancy
  a_r10_consistent: assert property (@(posedge clk) disable iff (rst)
    !occMismatch);

  // R7: idle permission only when nothing is outstanding
  a_r7_busy_idle: assert property (@(posedge clk) disable iff (rst)
    (!overridden && occupancy != '0) |-> busy);
endmodule

// File: tb/tb_idle_track.sv
module tb_idle_track;
  localparam int HL = 4;
  localparam int NS = 4;
  localparam int NW = 3;
  localparam int CW = $clog2(HL + NS + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic [NW-1:0] actStrobe;
  logic [NS-1:0] stageSetReq;
  logic [NS-1:0] stageClrReq;
  logic          loadEn;
  logic [CW-1:0] loadVal;
  logic [CW-1:0] actCount;
  logic          busy;
  logic          occMismatch;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  idle_track #(.HIST_LEN(HL), .NUM_STAGES(NS), .NUM_WRITERS(NW)) dut (
    .clk(clk), .rst(rst), .actStrobe(actStrobe), .stageSetReq(stageSetReq),
    .stageClrReq(stageClrReq), .loadEn(loadEn), .loadVal(loadVal),
    .actCount(actCount), .busy(busy), .occMismatch(occMismatch)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    actStrobe = '0; stageSetReq = '0; stageClrReq = '0; loadEn = 1'b0; loadVal = '0;
  endtask

  // one clock edge, return at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idleIn();
  endtask

  task automatic doReset();
    idleIn();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic checkState(input string tag, input int expCnt);
    check({tag, " count"}, int'(actCount), expCnt);
    check({tag, " busy R7"}, int'(busy), (expCnt != 0) ? 1 : 0);
  endtask

  task automatic testReset();
    doReset();
    actStrobe = 3'b001; stageSetReq = 4'b0011; step();
    actStrobe = 3'b010; rst = 1'b1; step();
    rst = 1'b0;
    checkState("R1 reset", 0);
    for (int i = 0; i < HL + 1; i++) step();
    checkState("R1 after release", 0);
    check("R1 mismatch", int'(occMismatch), 0);
  endtask

  task automatic testSingleStrobe();
    doReset();
    actStrobe = 3'b100; step();
    checkState("R2 single mark", 1);
    for (int i = 0; i < HL - 1; i++) step();
    checkState("R3 still in flight", 1);
    step();
    checkState("R3 aged out", 0);
    check("R10 mismatch", int'(occMismatch), 0);
  endtask

  task automatic testMultiWriter();
    doReset();
    actStrobe = 3'b111; step();
    checkState("R2 many writers one mark", 1);
    actStrobe = 3'b011; step();
    checkState("R2 second cycle mark", 2);
  endtask

  task automatic testStages();
    doReset();
    stageSetReq = 4'b0101; step();
    checkState("R4 two stages on", 2);
    stageClrReq = 4'b0001; step();
    checkState("R4 one stage off", 1);
    stageClrReq = 4'b0100; step();
    checkState("R4 all off R7 idle", 0);
  endtask

  task automatic testRedundant();
    doReset();
    stageSetReq = 4'b0010; step();
    checkState("R5 first set", 1);
    stageSetReq = 4'b0010; step();
    checkState("R5 repeat set ignored", 1);
    stageClrReq = 4'b0100; step();
    checkState("R5 clear of idle stage ignored", 1);
    stageSetReq = 4'b1000; stageClrReq = 4'b1000; step();
    checkState("R5 conflict ignored", 1);
    stageClrReq = 4'b1000; step();
    checkState("R5 conflict left stage off", 1);
    check("R5 mismatch", int'(occMismatch), 0);
  endtask

  task automatic testCombined();
    doReset();
    actStrobe = 3'b001; stageSetReq = 4'b0001; step();
    checkState("R6 setup", 2);
    for (int i = 0; i < HL - 1; i++) step();
    checkState("R6 before age out", 2);
    actStrobe = 3'b010; stageClrReq = 4'b0001; stageSetReq = 4'b0110; step();
    checkState("R6 net change", 3);
    check("R6 mismatch", int'(occMismatch), 0);
  endtask

  task automatic testLoad();
    doReset();
    stageSetReq = 4'b0011; step();
    checkState("R8 setup", 2);
    loadEn = 1'b1; loadVal = CW'(7); actStrobe = 3'b001; stageSetReq = 4'b0100; step();
    checkState("R8 loaded", 7);
    stageClrReq = 4'b0001; step();
    checkState("R8 counts on after load", 6);
    check("R10 held off after load", int'(occMismatch), 0);
  endtask

  task automatic testSaturate();
    doReset();
    loadEn = 1'b1; loadVal = '1; step();
    checkState("R9 loaded max", (1 << CW) - 1);
    actStrobe = 3'b001; stageSetReq = 4'b0001; step();
    checkState("R9 high saturate", (1 << CW) - 1);
    doReset();
    actStrobe = 3'b001; step();
    loadEn = 1'b1; loadVal = '0; step();
    checkState("R9 loaded zero", 0);
    for (int i = 0; i < HL; i++) step();
    checkState("R9 low saturate", 0);
  endtask

  initial begin
    idleIn();
    rst = 1'b1;
    @(negedge clk);
    testReset();
    testSingleStrobe();
    testMultiWriter();
    testStages();
    testRedundant();
    testCombined();
    testLoad();
    testSaturate();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule